// File: doc/BRIEF.md
# Battery Pack FET Protection Controller

This block holds the digital state behind the charge and discharge power-switch drives of a multi-cell battery protection front end. Three synchronized comparator flags report discharge overcurrent, discharge short circuit and charge overcurrent. Each flag feeds its own tick-driven timer. A fault is declared only when its flag has stayed high for the selected number of millisecond ticks.

A declared fault always sets a sticky status bit, and that bit enables the temperature-monitor supply. When the fault's automatic response is enabled, the fault also clears both FET control bits in hardware. The host owns the FET bits, the seven cell-balance enables, the per-fault response disables, the timeout codes and the discharge threshold code, and it writes them through a simple register strobe. A self-clearing sleep command drops every drive and balance output and the regulator enable.

Top module: `fet_guard`

## Requirements
- R1: `cfet` and `dfet` go to 1 only through a host write to select 0 (bit 0 = charge, bit 1 = discharge). A host write of 0 to a bit clears it.
- R2: The charge overcurrent fault is declared on the tick at which `coc_flag` has been high for 64 << code ticks. The code is bits 1:0 of select 3, giving 64, 128, 256 or 512. A drop of the flag before that point restarts the count.
- R3: The discharge overcurrent timeout is 8 << code ticks, with the code in bits 3:2 of select 3. The short-circuit timeout is fixed at 2 ticks. Cycles without `tick_ms` do not advance any timer.
- R4: When a fault is declared and its disable bit is 0, `cfet` and `dfet` are 0 after that clock edge. The disable bits are written through select 2: bit 0 for discharge overcurrent, bit 1 for short circuit, bit 2 for charge overcurrent. When the disable bit is 1, both FET bits keep their value.
- R5: A declared fault sets its bit in `fault_stat` whatever its disable bit holds. The bit order is bit 0 discharge overcurrent, bit 1 short circuit, bit 2 charge overcurrent. The bits stay set until a cycle with `stat_rd` high, which clears them. A fault declared in that same cycle remains set.
- R6: `temp_en` is 1 whenever any `fault_stat` bit is 1, and 0 otherwise.
- R7: If a host write sets a FET bit in the same cycle as an enabled fault is declared, the FET bit ends at 0.
- R8: Writing 1 to bit 2 of select 0 has these effects after that edge: `cfet`, `dfet`, `cb` and `reg_en` are 0, and `sleep_bit` is 1 for exactly one cycle. After that, writes to selects 0 and 1 have no effect until reset.
- R9: `doc_thr` equals bits 5:4 of the last write to select 3.
- R10: While `rst_n` is low, every output is 0. `reg_en` becomes 1 at the first clock edge after reset is released.
- R11: A write to select 1 drives `cb` from bits 6:0 of the write data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle millisecond tick |
| doc_flag | input | 1 | Discharge overcurrent comparator flag |
| dsc_flag | input | 1 | Discharge short-circuit comparator flag |
| coc_flag | input | 1 | Charge overcurrent comparator flag |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 2 | Register select (0 FET, 1 balance, 2 disables, 3 timing) |
| wr_data | input | 8 | Host write data |
| stat_rd | input | 1 | Status read strobe, clears status |
| cfet | output | 1 | Charge FET drive bit |
| dfet | output | 1 | Discharge FET drive bit |
| cb | output | 7 | Cell-balance enables |
| reg_en | output | 1 | Regulator enable |
| temp_en | output | 1 | Temperature-monitor supply enable |
| sleep_bit | output | 1 | Self-clearing sleep bit |
| doc_thr | output | 2 | Discharge overcurrent threshold code to comparator |
| fault_stat | output | 3 | Sticky fault status |

## Verification
Two pairs of events can land on the same edge. A host write that turns the FETs on can meet a fault clear, and a status read can meet a fault being set. The bench raises the short-circuit flag, whose two-tick timeout makes the expiry edge exact, and places the write or the read strobe on that edge. In the first case both FET bits must read 0. In the second case the status bit must survive the read and clear only on a later read.

// File: rtl/fg_pkg.sv
package fg_pkg;
    localparam int NCELL  = 7;
    localparam int NFAULT = 3;
    localparam int FT_DOC = 0;
    localparam int FT_DSC = 1;
    localparam int FT_COC = 2;

    typedef enum logic [1:0] {
        SEL_FET  = 2'd0,
        SEL_BAL  = 2'd1,
        SEL_PROT = 2'd2,
        SEL_TIME = 2'd3
    } fg_sel_e;

    typedef struct packed {
        logic              sleep;
        logic              asleep;
        logic              reg_en;
        logic              chg;
        logic              dsg;
        logic [NCELL-1:0]  bal;
        logic [NFAULT-1:0] stat;
        logic [NFAULT-1:0] dis;
        logic [1:0]        coc_code;
        logic [1:0]        doc_code;
        logic [1:0]        thr;
    } fg_ctrl_t;

    typedef struct packed {
        logic fired;
    } fg_tmr_flags_t;
endpackage

// File: rtl/fg_limit_sel.sv
module fg_limit_sel #(
    parameter int CW   = 10,
    parameter int BASE = 64
) (
    input  logic [1:0]    code,
    output logic [CW-1:0] limit
);
    always_comb begin
        limit = CW'(BASE) << code;
    end
endmodule

// File: rtl/fg_fault_timer.sv
module fg_fault_timer #(
    parameter int CW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flag,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          expire
);
    typedef struct packed {
        logic [CW-1:0] count;
        logic          fired;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic [CW-1:0] count_inc;

    always_comb begin
        tmr_d     = tmr_q;
        expire    = 1'b0;
        count_inc = tmr_q.count + CW'(1);
        if (!flag) begin
            tmr_d.count = '0;
            tmr_d.fired = 1'b0;
        end else if (tick && !tmr_q.fired) begin
            if (count_inc >= limit) begin
                expire      = 1'b1;
                tmr_d.fired = 1'b1;
                tmr_d.count = '0;
            end else begin
                tmr_d.count = count_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    // R2: a dropped flag restarts the count
    a_r2_drop_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        !flag |=> (tmr_q.count == '0 && !tmr_q.fired));
    // R3: a timer fires at most once per flag episode
    a_r3_fire_once: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.fired |-> !expire);
    // R3: a firing needs a tick with the flag high
    a_r3_tick_needed: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_q.fired) |-> $past(flag && tick));
endmodule

// File: rtl/fet_guard.sv
module fet_guard
    import fg_pkg::*;
#(
    parameter int COC_BASE = 64,
    parameter int DOC_BASE = 8,
    parameter int SC_TICKS = 2,
    parameter int DATA_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_ms,
    input  logic              doc_flag,
    input  logic              dsc_flag,
    input  logic              coc_flag,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              stat_rd,
    output logic              cfet,
    output logic              dfet,
    output logic [NCELL-1:0]  cb,
    output logic              reg_en,
    output logic              temp_en,
    output logic              sleep_bit,
    output logic [1:0]        doc_thr,
    output logic [NFAULT-1:0] fault_stat
);
    localparam int MAX_COC = COC_BASE * 8;
    localparam int MAX_DOC = DOC_BASE * 8;
    localparam int MAX_A   = (MAX_COC > MAX_DOC) ? MAX_COC : MAX_DOC;
    localparam int MAX_LIM = (MAX_A > SC_TICKS) ? MAX_A : SC_TICKS;
    localparam int CW      = $clog2(MAX_LIM + 1);

    fg_ctrl_t ctl_d, ctl_q;

    logic [NFAULT-1:0] flags;
    logic [NFAULT-1:0] expire;
    logic [NFAULT-1:0] trip;

    assign flags[FT_DOC] = doc_flag;
    assign flags[FT_DSC] = dsc_flag;
    assign flags[FT_COC] = coc_flag;

    for (genvar i = 0; i < NFAULT; i++) begin : g_fault
        localparam int BASE_I = (i == FT_COC) ? COC_BASE :
                                (i == FT_DOC) ? DOC_BASE : SC_TICKS;
        logic [1:0]    code_i;
        logic [CW-1:0] limit_i;

        if (i == FT_COC) begin : g_coc
            assign code_i = ctl_q.coc_code;
        end else if (i == FT_DOC) begin : g_doc
            assign code_i = ctl_q.doc_code;
        end else begin : g_fixed
            assign code_i = 2'b00;
        end

        fg_limit_sel #(.CW(CW), .BASE(BASE_I)) u_lim (
            .code  (code_i),
            .limit (limit_i)
        );

        fg_fault_timer #(.CW(CW)) u_tmr (
            .clk    (clk),
            .rst_n  (rst_n),
            .flag   (flags[i]),
            .tick   (tick_ms),
            .limit  (limit_i),
            .expire (expire[i])
        );

        // R5: status holds until a read strobe
        a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (fault_stat[i] && !stat_rd) |=> fault_stat[i]);
        // R5: an expiry always lands in status
        a_r5_expiry_sets: assert property (@(posedge clk) disable iff (!rst_n)
            expire[i] |=> fault_stat[i]);
    end

    assign trip = expire & ~ctl_q.dis;

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.sleep = 1'b0;

        if (stat_rd) ctl_d.stat = '0;
        ctl_d.stat = ctl_d.stat | expire;

        if (wr_en) begin
            case (fg_sel_e'(wr_sel))
                SEL_FET: begin
                    if (!ctl_q.asleep) begin
                        ctl_d.chg = wr_data[0];
                        ctl_d.dsg = wr_data[1];
                        if (wr_data[2]) begin
                            ctl_d.chg    = 1'b0;
                            ctl_d.dsg    = 1'b0;
                            ctl_d.bal    = '0;
                            ctl_d.sleep  = 1'b1;
                            ctl_d.asleep = 1'b1;
                        end
                    end
                end
                SEL_BAL: begin
                    if (!ctl_q.asleep) ctl_d.bal = wr_data[NCELL-1:0];
                end
                SEL_PROT: begin
                    ctl_d.dis = wr_data[NFAULT-1:0];
                end
                SEL_TIME: begin
                    ctl_d.coc_code = wr_data[1:0];
                    ctl_d.doc_code = wr_data[3:2];
                    ctl_d.thr      = wr_data[5:4];
                end
                default: ;
            endcase
        end

        if (|trip) begin
            ctl_d.chg = 1'b0;
            ctl_d.dsg = 1'b0;
        end

        ctl_d.reg_en = ~ctl_d.asleep;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign cfet       = ctl_q.chg;
    assign dfet       = ctl_q.dsg;
    assign cb         = ctl_q.bal;
    assign reg_en     = ctl_q.reg_en;
    assign sleep_bit  = ctl_q.sleep;
    assign doc_thr    = ctl_q.thr;
    assign fault_stat = ctl_q.stat;
    assign temp_en    = |ctl_q.stat;

    // R1: the charge drive rises only through a host write
    a_r1_cfet_by_host: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfet) |-> $past(wr_en && wr_sel == 2'd0 && wr_data[0]));
    // R1: the discharge drive rises only through a host write
    a_r1_dfet_by_host: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dfet) |-> $past(wr_en && wr_sel == 2'd0 && wr_data[1]));
    // R4, R7: an enabled expiry leaves both drives off
    a_r4_trip_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (|(expire & ~ctl_q.dis)) |=> (!cfet && !dfet));
    // R6: a charge overcurrent expiry powers the temperature monitor
    a_r6_temp_on_coc: assert property (@(posedge clk) disable iff (!rst_n)
        expire[FT_COC] |=> temp_en);
    // R8: the sleep command shuts every output down
    a_r8_sleep_effects: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0 && wr_data[2] && !ctl_q.asleep)
        |=> (sleep_bit && !cfet && !dfet && cb == '0 && !reg_en));
    // R8: the sleep bit clears itself
    a_r8_sleep_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_bit |=> !sleep_bit);
endmodule

// File: tb/fet_guard_test.sv
module fet_guard_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_ms = 1'b1;
    logic [2:0] flg = 3'b000;
    logic       wr_en = 1'b0;
    logic [1:0] wr_sel = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       stat_rd = 1'b0;
    logic       cfet, dfet, reg_en, temp_en, sleep_bit;
    logic [6:0] cb;
    logic [1:0] doc_thr;
    logic [2:0] fault_stat;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fet_guard uut (
        .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms),
        .doc_flag(flg[0]), .dsc_flag(flg[1]), .coc_flag(flg[2]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data), .stat_rd(stat_rd),
        .cfet(cfet), .dfet(dfet), .cb(cb), .reg_en(reg_en), .temp_en(temp_en),
        .sleep_bit(sleep_bit), .doc_thr(doc_thr), .fault_stat(fault_stat)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_clear();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    initial begin
        cyc(3);
        // R10: reset state
        chk("R10 outputs in reset", {cfet, dfet, cb, reg_en, temp_en, sleep_bit, doc_thr, fault_stat}, 0);
        rst_n = 1'b1;
        cyc(1);
        chk("R10 reg_en after release", reg_en, 1);

        // R1: host drives FET bits
        wr(2'd0, 8'h01);
        chk("R1 cfet set", cfet, 1);
        chk("R1 dfet untouched", dfet, 0);
        wr(2'd0, 8'h02);
        chk("R1 cfet cleared by host", cfet, 0);
        chk("R1 dfet set", dfet, 1);
        wr(2'd0, 8'h00);
        chk("R1 both cleared", {cfet, dfet}, 0);

        // R11: balance sweep
        for (int i = 0; i < 7; i++) begin
            wr(2'd1, 8'(1 << i));
            chk("R11 balance one-hot", cb, 1 << i);
        end
        wr(2'd1, 8'h7F);
        chk("R11 balance all", cb, 127);

        // R9: threshold pass-through
        for (int t = 0; t < 4; t++) begin
            wr(2'd3, 8'(t << 4));
            chk("R9 threshold code", doc_thr, t);
        end

        // R2, R4, R6: charge overcurrent timeout per code
        for (int c = 0; c < 4; c++) begin
            int lim;
            lim = 64 << c;
            wr(2'd3, 8'(c));
            rd_clear();
            chk("R6 temp_en idle", temp_en, 0);
            wr(2'd0, 8'h03);
            flg[2] = 1'b1;
            cyc(lim - 1);
            chk("R2 coc not yet", fault_stat[2], 0);
            chk("R2 cfet held before expiry", cfet, 1);
            cyc(1);
            chk("R2 coc at timeout", fault_stat[2], 1);
            chk("R4 fets cleared on coc", {cfet, dfet}, 0);
            chk("R6 temp_en on coc", temp_en, 1);
            flg[2] = 1'b0;
            cyc(1);
        end

        // R3: discharge overcurrent timeout per code, with restart
        for (int c = 0; c < 4; c++) begin
            int lim;
            lim = 8 << c;
            wr(2'd3, 8'(c << 2));
            rd_clear();
            flg[0] = 1'b1;
            cyc(lim - 1);
            flg[0] = 1'b0;
            cyc(1);
            flg[0] = 1'b1;
            cyc(lim - 1);
            chk("R3 doc restart no fault", fault_stat[0], 0);
            cyc(1);
            chk("R3 doc at timeout", fault_stat[0], 1);
            flg[0] = 1'b0;
            cyc(1);
        end

        // R3: ticks gate the count (doc code 0, 8 ticks)
        wr(2'd3, 8'h00);
        rd_clear();
        flg[0] = 1'b1;
        for (int k = 0; k < 14; k++) begin
            tick_ms = (k % 2 == 0);
            @(negedge clk);
        end
        chk("R3 seven ticks no fault", fault_stat[0], 0);
        tick_ms = 1'b1;
        cyc(1);
        chk("R3 eighth tick fault", fault_stat[0], 1);
        flg[0] = 1'b0;
        cyc(1);

        // R3: short circuit fixed 2 ticks
        rd_clear();
        flg[1] = 1'b1;
        cyc(1);
        chk("R3 dsc after one tick", fault_stat[1], 0);
        cyc(1);
        chk("R3 dsc after two ticks", fault_stat[1], 1);
        flg[1] = 1'b0;
        cyc(1);

        // R4, R5: disable bits keep FETs but still set status
        for (int i = 0; i < 3; i++) begin
            int lim;
            lim = (i == 0) ? 8 : (i == 1) ? 2 : 64;
            wr(2'd2, 8'(1 << i));
            rd_clear();
            wr(2'd0, 8'h03);
            flg[i] = 1'b1;
            cyc(lim);
            chk("R5 status set while disabled", fault_stat, 1 << i);
            chk("R4 fets kept while disabled", {cfet, dfet}, 3);
            flg[i] = 1'b0;
            cyc(1);
        end
        wr(2'd2, 8'h00);

        // R7: host set collides with fault clear
        wr(2'd0, 8'h00);
        rd_clear();
        flg[1] = 1'b1;
        cyc(1);
        wr(2'd0, 8'h03);
        chk("R7 clear wins over set", {cfet, dfet}, 0);
        chk("R7 status set", fault_stat[1], 1);
        flg[1] = 1'b0;
        cyc(1);
        // R7 control: same write without a fault goes through
        wr(2'd0, 8'h03);
        chk("R7 write alone sets", {cfet, dfet}, 3);

        // R5: read collides with set
        flg[1] = 1'b1;
        cyc(1);
        stat_rd = 1'b1;
        cyc(1);
        stat_rd = 1'b0;
        chk("R5 set wins over read", fault_stat[1], 1);
        flg[1] = 1'b0;
        cyc(1);
        chk("R5 sticky without read", fault_stat[1], 1);
        rd_clear();
        chk("R5 cleared on read", fault_stat, 0);
        chk("R6 temp_en off after read", temp_en, 0);

        // R8: sleep
        wr(2'd0, 8'h03);
        wr(2'd1, 8'h7F);
        wr_en = 1'b1; wr_sel = 2'd0; wr_data = 8'h07;
        cyc(1);
        wr_en = 1'b0;
        chk("R8 sleep bit set", sleep_bit, 1);
        chk("R8 fets off", {cfet, dfet}, 0);
        chk("R8 balance off", cb, 0);
        chk("R8 regulator off", reg_en, 0);
        cyc(1);
        chk("R8 sleep bit self clears", sleep_bit, 0);
        wr(2'd0, 8'h03);
        chk("R8 fet write ignored", {cfet, dfet}, 0);
        wr(2'd1, 8'h7F);
        chk("R8 balance write ignored", cb, 0);
        chk("R8 regulator stays off", reg_en, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule